// File: doc/BRIEF.md
# Legacy Memory Routing Decoder

This block sits in a host bridge and turns a handful of configuration bytes into routing decisions for the legacy address space below 1 MB. Seven attribute bytes hold thirteen 2-bit fields, one for each shadowable region: a 64 KB boot-firmware region at the top of the space and twelve 16 KB option-ROM regions below it. A separate control byte governs the 128 KB graphics/SMRAM window. A read-only byte reports the installed memory size.

Every cycle the block looks at one access address, its direction and whether it comes from system-management mode. It reports whether that access should be claimed by DRAM or passed to the PCI bus. It also reports whether the window is currently open as RAM for ordinary accesses. Configuration bytes are written and read one at a time through a small byte port. A write is registered, so the new routing applies from the following cycle. Memory data never passes through the block.

Top module: `legacy_mem_router`

## Requirements
- R1: After reset, all seven attribute bytes (offsets 0x59 to 0x5F) read 0x00 and the SMRAM control byte at offset 0x72 reads 0x02.
- R2: A write to offsets 0x59 to 0x5F or 0x72 stores the whole byte, and reading the same offset returns it. Reads of other offsets return 0x00, except 0x57. Writes to other offsets change no stored state.
- R3: Offset 0x57 reads the memory size in 8 MB units, computed from the RAM_MB parameter and clamped at 255. Writes to it are ignored.
- R4: Any access below 0xA0000 is routed to DRAM (to_dram_o = 1).
- R5: Region 0 spans 0xF0000 to 0xFFFFF and takes its field from bits [5:4] of offset 0x59. Region i (1 to 12) spans 16 KB from 0xC0000 + (i-1)*0x4000. It takes its field from offset 0x59 + (i+1)/2, using bits [1:0] when i is odd and bits [5:4] when i is even.
- R6: Within a field, bit 0 sends reads to DRAM and bit 1 sends writes to DRAM. A read or write whose bit is 0 goes to PCI (to_dram_o = 0).
- R7: For an access to 0xA0000 to 0xBFFFF that is not an SMM access, or when bit 3 of offset 0x72 is 0, the access goes to DRAM only if bit 6 of offset 0x72 is 1, and to PCI otherwise. win_ram_o always equals bit 6 of offset 0x72.
- R8: An SMM access to 0xA0000 to 0xBFFFF goes to DRAM whenever bit 3 of offset 0x72 is 1, whatever bit 6 holds. SMM accesses elsewhere follow R4 to R6.
- R9: A configuration write takes effect on routing from the next cycle. An access presented in the same cycle as the write is routed by the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration byte write strobe |
| cfg_addr_i | input | 8 | Configuration byte offset |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data for cfg_addr_i |
| acc_addr_i | input | 20 | Access address below 1 MB |
| acc_write_i | input | 1 | 1 = write access, 0 = read access |
| acc_smm_i | input | 1 | Access issued in system-management mode |
| to_dram_o | output | 1 | 1 = DRAM claims the access, 0 = PCI bus |
| win_ram_o | output | 1 | Window 0xA0000 to 0xBFFFF open as RAM for ordinary accesses |

## Verification
A configuration write and a routing lookup can land in the same cycle, and they can touch the same region or window. In that cycle the lookup must still see the old attribute or control value. The bench provokes this with directed cycles that rewrite a field while an access to that region is presented. It then continues with random traffic that mixes writes to the live offsets with lookups in every zone. A behavioural model applies each write only after the cycle's comparison, so an early update shows up as a routing mismatch tagged R9.

// File: rtl/lmr_pkg.sv
`timescale 1ns/1ps
package lmr_pkg;
  localparam int ADDR_W      = 20;
  localparam int CFG_AW      = 8;
  localparam int ATTR_BASE   = 'h59;
  localparam int ATTR_N      = 7;
  localparam int SMRAM_OFF   = 'h72;
  localparam int SIZE_OFF    = 'h57;
  localparam logic [7:0] SMRAM_RST = 8'h02;
  localparam int OPEN_BIT    = 6;
  localparam int GLOBAL_BIT  = 3;
  localparam int WIN_LO      = 'hA0000;
  localparam int WIN_SZ      = 'h20000;
  localparam int EXP_LO      = 'hC0000;
  localparam int EXP_SZ      = 'h4000;
  localparam int BIOS_LO     = 'hF0000;
  localparam int BIOS_SZ     = 'h10000;
  localparam int NUM_REG     = 13;

  typedef logic [ATTR_N-1:0][7:0] attr_bank_t;
endpackage

// File: rtl/lmr_cfg_regs.sv
`timescale 1ns/1ps
module lmr_cfg_regs
  import lmr_pkg::*;
#(
  parameter int RAM_MB = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output attr_bank_t        attr_o,
  output logic [7:0]        smram_o
);
  localparam int SIZE_UNITS = (RAM_MB / 8 > 255) ? 255 : RAM_MB / 8;
  localparam logic [7:0] SIZE_BYTE = 8'(SIZE_UNITS);

  attr_bank_t attr_q;
  logic [7:0] smram_q;
  logic       attr_hit;
  logic       smram_hit;

  assign attr_hit  = (int'(addr_i) >= ATTR_BASE) && (int'(addr_i) < ATTR_BASE + ATTR_N);
  assign smram_hit = (int'(addr_i) == SMRAM_OFF);

  for (genvar g = 0; g < ATTR_N; g++) begin : g_attr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                             attr_q[g] <= '0;
      else if (we_i && int'(addr_i) == ATTR_BASE + g)          attr_q[g] <= wdata_i;
    end

    p_attr_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && int'(addr_i) == ATTR_BASE + g) |=> (attr_o[g] == $past(wdata_i)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               smram_q <= SMRAM_RST;
    else if (we_i && smram_hit) smram_q <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    if (attr_hit) begin
      for (int k = 0; k < ATTR_N; k++)
        if (int'(addr_i) == ATTR_BASE + k) rdata_o = attr_q[k];
    end else if (smram_hit) begin
      rdata_o = smram_q;
    end else if (int'(addr_i) == SIZE_OFF) begin
      rdata_o = SIZE_BYTE;
    end
  end

  assign attr_o  = attr_q;
  assign smram_o = smram_q;

  p_unmapped_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !attr_hit && !smram_hit) |=> ($stable(attr_o) && $stable(smram_o)));

  p_smram_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && smram_hit) |=> $stable(smram_o));
endmodule

// File: rtl/lmr_region_decode.sv
`timescale 1ns/1ps
module lmr_region_decode
  import lmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  attr_bank_t        attr_i,
  output logic              hit_o,
  output logic              allow_o
);
  logic [NUM_REG-1:0]      hit;
  logic [NUM_REG-1:0][1:0] fld;

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    localparam int LO  = (r == 0) ? BIOS_LO : EXP_LO + (r - 1) * EXP_SZ;
    localparam int SZ  = (r == 0) ? BIOS_SZ : EXP_SZ;
    localparam int IDX = (r + 1) / 2;
    assign hit[r] = (int'(addr_i) >= LO) && (int'(addr_i) < LO + SZ);
    if (r == 0 || (r % 2) == 0) begin : g_hi
      assign fld[r] = attr_i[IDX][5:4];
    end else begin : g_lo
      assign fld[r] = attr_i[IDX][1:0];
    end
  end

  always_comb begin
    allow_o = 1'b0;
    for (int r = 0; r < NUM_REG; r++)
      if (hit[r]) allow_o = allow_o | (write_i ? fld[r][1] : fld[r][0]);
  end

  assign hit_o = |hit;

  p_one_region_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
endmodule

// File: rtl/lmr_smram_decode.sv
`timescale 1ns/1ps
module lmr_smram_decode
  import lmr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              smm_i,
  input  logic [7:0]        ctrl_i,
  output logic              hit_o,
  output logic              dram_o,
  output logic              open_o
);
  assign hit_o  = (int'(addr_i) >= WIN_LO) && (int'(addr_i) < WIN_LO + WIN_SZ);
  assign open_o = ctrl_i[OPEN_BIT];
  // SMM with global enable bypasses the open bit
  assign dram_o = (smm_i && ctrl_i[GLOBAL_BIT]) || ctrl_i[OPEN_BIT];
endmodule

// File: rtl/legacy_mem_router.sv
`timescale 1ns/1ps
module legacy_mem_router
  import lmr_pkg::*;
#(
  parameter int RAM_MB = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_write_i,
  input  logic              acc_smm_i,
  output logic              to_dram_o,
  output logic              win_ram_o
);
  attr_bank_t attr;
  logic [7:0] smram;
  logic       reg_hit, reg_allow;
  logic       win_hit, win_dram, win_open;

  lmr_cfg_regs #(.RAM_MB(RAM_MB)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .attr_o  (attr),
    .smram_o (smram)
  );

  lmr_region_decode u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (acc_addr_i),
    .write_i (acc_write_i),
    .attr_i  (attr),
    .hit_o   (reg_hit),
    .allow_o (reg_allow)
  );

  lmr_smram_decode u_win (
    .addr_i (acc_addr_i),
    .smm_i  (acc_smm_i),
    .ctrl_i (smram),
    .hit_o  (win_hit),
    .dram_o (win_dram),
    .open_o (win_open)
  );

  always_comb begin
    if (win_hit)      to_dram_o = win_dram;
    else if (reg_hit) to_dram_o = reg_allow;
    else              to_dram_o = 1'b1;
  end

  assign win_ram_o = win_open;

  p_low_dram_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(acc_addr_i) < WIN_LO) |-> to_dram_o);

  p_smm_global_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_hit && acc_smm_i && smram[GLOBAL_BIT]) |-> to_dram_o);

  p_win_closed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_hit && !acc_smm_i && !win_ram_o) |-> !to_dram_o);

  p_region_decoded_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(acc_addr_i) >= EXP_LO) |-> reg_hit);
endmodule

// File: tb/sim_legacy_mem_router.sv
`timescale 1ns/1ps
module sim_legacy_mem_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata, rdata1;
  logic [19:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        acc_smm = 1'b0;
  logic        to_dram, win_ram, dram1, win1;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int cfgm [256];

  always #2.5 clk = ~clk;

  legacy_mem_router #(.RAM_MB(128)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .acc_addr_i(acc_addr),
    .acc_write_i(acc_write), .acc_smm_i(acc_smm), .to_dram_o(to_dram), .win_ram_o(win_ram));

  legacy_mem_router #(.RAM_MB(4096)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(1'b0), .cfg_addr_i(8'h57),
    .cfg_wdata_i(8'h00), .cfg_rdata_o(rdata1), .acc_addr_i(acc_addr),
    .acc_write_i(acc_write), .acc_smm_i(acc_smm), .to_dram_o(dram1), .win_ram_o(win1));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_read(int off);
    if ((off >= 'h59 && off <= 'h5F) || off == 'h72) return cfgm[off];
    if (off == 'h57) return 16;
    return 0;
  endfunction

  function automatic int exp_route(int a, bit wr, bit smm);
    int r, byt, f;
    if (a < 'hA0000) return 1;
    if (a < 'hC0000) begin
      if (smm && cfgm['h72][3]) return 1;
      return cfgm['h72][6];
    end
    r   = (a >= 'hF0000) ? 0 : (a - 'hC0000) / 'h4000 + 1;
    byt = cfgm['h59 + (r + 1) / 2];
    f   = (r == 0 || r % 2 == 0) ? (byt >> 4) & 3 : byt & 3;
    return wr ? (f >> 1) & 1 : f & 1;
  endfunction

  function automatic string route_tag(int a, bit smm, bit wr_now);
    if (wr_now) return "R9";
    if (a < 'hA0000) return "R4";
    if (a < 'hC0000) return (smm && cfgm['h72][3]) ? "R8" : "R7";
    return "R5_R6";
  endfunction

  // one cycle: drive after falling edge, compare, then commit the write to the model
  task automatic cyc(bit we, int off, int wd, int a, bit wr, bit smm);
    bit live;
    @(negedge clk);
    cfg_we = we; cfg_addr = 8'(off); cfg_wdata = 8'(wd);
    acc_addr = 20'(a); acc_write = wr; acc_smm = smm;
    #1;
    live = we && ((off >= 'h59 && off <= 'h5F) || off == 'h72);
    check(route_tag(a, smm, live), int'(to_dram), exp_route(a, wr, smm));
    check("R7", int'(win_ram), cfgm['h72][6]);
    check((off == 'h57) ? "R3" : "R2", int'(cfg_rdata), exp_read(off));
    if (live) cfgm[off] = wd & 'hFF;
  endtask

  function automatic int pick_addr();
    case ($urandom % 4)
      0: return $urandom % 'hA0000;
      1: return 'hA0000 + $urandom % 'h20000;
      2: return 'hC0000 + $urandom % 'h30000;
      default: return 'hF0000 + $urandom % 'h10000;
    endcase
  endfunction

  function automatic int pick_off();
    case ($urandom % 5)
      0: return 'h59 + $urandom % 7;
      1: return 'h72;
      2: return 'h57;
      3: return $urandom % 256;
      default: return 'h59 + $urandom % 7;
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) cfgm[i] = 0;
    cfgm['h72] = 2;
    // R1: reset contents visible while reset is held
    #7;
    cfg_addr = 8'h72; #1;
    check("R1", int'(cfg_rdata), 2);
    cfg_addr = 8'h5C; #1;
    check("R1", int'(cfg_rdata), 0);
    acc_addr = 20'hB0000; #1;
    check("R1", int'(to_dram), 0);
    @(negedge clk); rst_n = 1'b1;
    check("R3", int'(rdata1), 255);

    cyc(0, 'h59, 0, 'h12345, 0, 0);                  // R4
    cyc(1, 'h59, 'h30, 'hF8000, 0, 0);               // R9: same-cycle read sees old field
    cyc(0, 'h59, 0, 'hF8000, 0, 0);                  // R6 read enabled
    cyc(0, 'h59, 0, 'hFFFFF, 1, 0);                  // R6 write enabled
    cyc(1, 'h5A, 'h12, 'hC0000, 1, 0);               // region 1 low nibble
    cyc(0, 'h5A, 0, 'hC0000, 1, 0);                  // R5 write only
    cyc(0, 'h5A, 0, 'hC3FFF, 0, 0);                  // R6 read blocked
    cyc(0, 'h5A, 0, 'hC4000, 0, 0);                  // R5 region 2 high nibble read
    cyc(1, 'h5F, 'h20, 'hEC000, 1, 0);               // R5 region 12
    cyc(0, 'h5F, 0, 'hEFFFF, 1, 0);
    cyc(0, 'h5F, 0, 'hE8000, 1, 0);                  // region 11 stays PCI
    cyc(1, 'h57, 'h99, 'hA0000, 0, 1);               // R3 write ignored
    cyc(0, 'h57, 0, 'hA0000, 0, 1);
    cyc(1, 'h10, 'hFF, 'hBFFFF, 0, 0);               // R2 unmapped write ignored
    cyc(0, 'h10, 0, 'hBFFFF, 0, 0);
    cyc(1, 'h72, 'h08, 'hA8000, 1, 1);               // R8 global enable
    cyc(0, 'h72, 0, 'hA8000, 1, 1);
    cyc(0, 'h72, 0, 'hA8000, 1, 0);                  // R7 closed for ordinary
    cyc(1, 'h72, 'h40, 'hB0000, 0, 0);               // R7 open
    cyc(0, 'h72, 0, 'hB0000, 0, 0);

    for (int n = 0; n < 4000; n++)
      cyc(($urandom % 3) == 0, pick_off(), $urandom % 256, pick_addr(),
          $urandom % 2, ($urandom % 4) == 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule